// File: doc/BRIEF.md
# HDLC Masked Address Recognizer

This block sits on the receive side of an HDLC link, after flag detection and zero-bit removal. It sees the byte stream of one frame at a time. A start marker tags the byte that directly follows the opening 0x7E flag, and an end marker tags the last byte of the frame. The first two bytes of each frame are joined into a 16-bit address field. The field is then compared against four programmable address entries. The compare covers only the bit positions that a single shared mask selects. The block reports a keep-or-drop verdict before any body byte is passed on.

A mask of 0xFFFF gives full 16-bit station recognition. A second entry set to 0xFFFF then acts as a broadcast address. A mask of 0x00FF gives 8-bit recognition. In that mode only the first address byte counts, and the upper half of every entry is ignored. The verdict comes out one cycle after the second address byte in both modes, so the downstream timing never depends on the mask.

Top module: `hdlc_addr_filter`

## Requirements
- R1: While reset is held and directly after it, `dec_vld_o`, `accept_o` and `discard_o` are 0 and `idx_o` is 0.
- R2: The first address byte (the byte with `sof_i`) is the low half of the 16-bit field and the second byte is the high half. Bytes 0x68 then 0xAA form 0xAA68.
- R3: With mask 0xFFFF a frame is accepted only if all 16 bits of the field equal some entry. A difference in any single bit causes a discard.
- R4: With mask 0x00FF only the first address byte is compared against the low byte of each entry. The second byte and the entries' upper bytes have no effect on the verdict.
- R5: A frame is accepted when its field matches any one of the four entries under the mask. A 16-bit broadcast value of 0xFFFF held in one entry is recognised alongside a station address held in another.
- R6: When several entries match, `idx_o` reports the lowest-numbered matching entry, with entry k held in `cfg_addr_i[16k+15:16k]`. Entries that repeat one value act as a single address.
- R7: `dec_vld_o` pulses for exactly one cycle, in the cycle after the second address byte is presented. The timing is the same under both masks. During that pulse exactly one of `accept_o` and `discard_o` is 1. `idx_o` changes only together with an accept and holds its value otherwise.
- R8: A frame whose end marker comes on its first address byte is a runt. It gives one `dec_vld_o` pulse with `discard_o` = 1, `accept_o` = 0, and `idx_o` unchanged.
- R9: Cycles with `byte_vld_i` low, bytes that arrive outside a frame, and body bytes after the address produce no decision and do not alter the captured field.
- R10: A start marker in the middle of a frame abandons that frame, and its byte becomes the first address byte of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | A received byte is present this cycle |
| byte_i | input | 8 | Received byte |
| sof_i | input | 1 | This byte is the first after the opening flag |
| eof_i | input | 1 | This byte is the last of the frame |
| cfg_mask_i | input | 16 | Shared compare mask; a 1 bit takes part in the compare |
| cfg_addr_i | input | 64 | Four 16-bit address entries, entry k in bits 16k+15:16k |
| dec_vld_o | output | 1 | One-cycle verdict strobe |
| accept_o | output | 1 | Frame accepted (valid with `dec_vld_o`) |
| discard_o | output | 1 | Frame discarded (valid with `dec_vld_o`) |
| idx_o | output | 2 | Index of the lowest matching entry of the last accepted frame |

## Verification
Two events can fall in the same cycle: the end of a frame and the second address byte. A two-byte frame carries its end marker on that second byte. The bench drives exactly this case and expects a normal accept with the matching index, not a runt discard. It also drives a start marker together with an end marker on one byte, and expects a single discard strobe with the held index unchanged. A second collision is a new start marker arriving while a frame is still waiting for its second byte. That is judged by the verdict of the restarted frame alone.

// File: rtl/hdlc_addr_pkg.sv
package hdlc_addr_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_LO   = 2'd1,
        CAP_BODY = 2'd2
    } cap_state_e;

endpackage

// File: rtl/hdlc_addr_capture.sv
module hdlc_addr_capture
    import hdlc_addr_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int FLD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              sof_i,
    input  logic              eof_i,
    output logic [FLD_W-1:0]  fld_o,
    output logic              take_o,
    output logic              runt_o
);

    typedef struct packed {
        cap_state_e        st;
        logic [BYTE_W-1:0] lo;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d  = cap_q;
        take_o = 1'b0;
        runt_o = 1'b0;
        if (byte_vld_i) begin
            if (sof_i) begin
                if (eof_i) begin
                    runt_o   = 1'b1;
                    cap_d.st = CAP_IDLE;
                end else begin
                    cap_d.lo = byte_i;
                    cap_d.st = CAP_LO;
                end
            end else begin
                unique case (cap_q.st)
                    CAP_LO: begin
                        take_o   = 1'b1;
                        cap_d.st = eof_i ? CAP_IDLE : CAP_BODY;
                    end
                    CAP_BODY: begin
                        if (eof_i) cap_d.st = CAP_IDLE;
                    end
                    default: cap_d.st = CAP_IDLE;
                endcase
            end
        end
    end

    assign fld_o = {byte_i, cap_q.lo};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q.st <= CAP_IDLE;
            cap_q.lo <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

endmodule

// File: rtl/hdlc_addr_match.sv
module hdlc_addr_match #(
    parameter int NUM_ADDR = 4,
    parameter int ADDR_W   = 16,
    localparam int IDX_W   = (NUM_ADDR > 1) ? $clog2(NUM_ADDR) : 1
) (
    input  logic [ADDR_W-1:0]          fld_i,
    input  logic [ADDR_W-1:0]          mask_i,
    input  logic [NUM_ADDR*ADDR_W-1:0] addr_i,
    output logic                       hit_o,
    output logic [IDX_W-1:0]           idx_o
);

    logic [NUM_ADDR-1:0] hit;

    for (genvar g = 0; g < NUM_ADDR; g++) begin : g_ent
        assign hit[g] = ~|((fld_i ^ addr_i[g*ADDR_W +: ADDR_W]) & mask_i);
    end

    always_comb begin
        idx_o = '0;
        for (int i = NUM_ADDR - 1; i >= 0; i--) begin
            if (hit[i]) idx_o = IDX_W'(i);
        end
    end

    assign hit_o = |hit;

endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter #(
    parameter int NUM_ADDR = 4,
    parameter int BYTE_W   = 8,
    localparam int ADDR_W  = 2 * BYTE_W,
    localparam int IDX_W   = (NUM_ADDR > 1) ? $clog2(NUM_ADDR) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       byte_vld_i,
    input  logic [BYTE_W-1:0]          byte_i,
    input  logic                       sof_i,
    input  logic                       eof_i,
    input  logic [ADDR_W-1:0]          cfg_mask_i,
    input  logic [NUM_ADDR*ADDR_W-1:0] cfg_addr_i,
    output logic                       dec_vld_o,
    output logic                       accept_o,
    output logic                       discard_o,
    output logic [IDX_W-1:0]           idx_o
);

    typedef struct packed {
        logic             dec;
        logic             acc;
        logic             dis;
        logic [IDX_W-1:0] idx;
    } verdict_t;

    verdict_t vd_d, vd_q;

    logic [ADDR_W-1:0] fld;
    logic              take;
    logic              runt;
    logic              any_hit;
    logic [IDX_W-1:0]  hit_idx;

    hdlc_addr_capture #(
        .BYTE_W (BYTE_W)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_vld_i (byte_vld_i),
        .byte_i     (byte_i),
        .sof_i      (sof_i),
        .eof_i      (eof_i),
        .fld_o      (fld),
        .take_o     (take),
        .runt_o     (runt)
    );

    hdlc_addr_match #(
        .NUM_ADDR (NUM_ADDR),
        .ADDR_W   (ADDR_W)
    ) u_cmp (
        .fld_i  (fld),
        .mask_i (cfg_mask_i),
        .addr_i (cfg_addr_i),
        .hit_o  (any_hit),
        .idx_o  (hit_idx)
    );

    always_comb begin
        vd_d     = vd_q;
        vd_d.dec = take | runt;
        vd_d.acc = take & any_hit;
        vd_d.dis = runt | (take & ~any_hit);
        if (take && any_hit) vd_d.idx = hit_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vd_q <= '0;
        end else begin
            vd_q <= vd_d;
        end
    end

    assign dec_vld_o = vd_q.dec;
    assign accept_o  = vd_q.acc;
    assign discard_o = vd_q.dis;
    assign idx_o     = vd_q.idx;

endmodule

// File: rtl/hdlc_addr_filter_chk.sv
module hdlc_addr_filter_chk #(
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_vld_i,
    input logic             sof_i,
    input logic             eof_i,
    input logic             dec_vld_o,
    input logic             accept_o,
    input logic             discard_o,
    input logic [IDX_W-1:0] idx_o
);

    p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld_o |-> (accept_o ^ discard_o));

    p_quiet_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_vld_o |-> (!accept_o && !discard_o));

    p_idx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_o |=> (!accept_o || 1'b1) && ($stable(idx_o) || $past(accept_o) || accept_o));

    p_runt_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && sof_i && eof_i) |=> (dec_vld_o && discard_o && !accept_o));

    p_runt_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && sof_i && eof_i) |=> $stable(idx_o));

    p_no_idle_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld_i |=> !dec_vld_o);

    p_no_dec_on_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && sof_i && !eof_i) |=> !dec_vld_o);

endmodule

bind hdlc_addr_filter hdlc_addr_filter_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_vld_i (byte_vld_i),
    .sof_i      (sof_i),
    .eof_i      (eof_i),
    .dec_vld_o  (dec_vld_o),
    .accept_o   (accept_o),
    .discard_o  (discard_o),
    .idx_o      (idx_o)
);

// File: tb/hdlc_addr_filter_bench.sv
module hdlc_addr_filter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic        sof_i = 1'b0;
    logic        eof_i = 1'b0;
    logic [15:0] cfg_mask_i = '0;
    logic [63:0] cfg_addr_i = '0;
    logic        dec_vld_o;
    logic        accept_o;
    logic        discard_o;
    logic [1:0]  idx_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hdlc_addr_filter u_hdlc_addr_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_vld_i (byte_vld_i),
        .byte_i     (byte_i),
        .sof_i      (sof_i),
        .eof_i      (eof_i),
        .cfg_mask_i (cfg_mask_i),
        .cfg_addr_i (cfg_addr_i),
        .dec_vld_o  (dec_vld_o),
        .accept_o   (accept_o),
        .discard_o  (discard_o),
        .idx_o      (idx_o)
    );

    task automatic chk(input logic dec, input logic acc, input logic dis,
                       input logic [1:0] idx, input string tag);
        checks++;
        if (dec_vld_o !== dec || accept_o !== acc || discard_o !== dis || idx_o !== idx) begin
            errors++;
            $display("FAIL %s: got dec=%b acc=%b dis=%b idx=%0d, expected dec=%b acc=%b dis=%b idx=%0d",
                     tag, dec_vld_o, accept_o, discard_o, idx_o, dec, acc, dis, idx);
        end
    endtask

    task automatic chk_quiet(input string tag);
        checks++;
        if (dec_vld_o !== 1'b0 || accept_o !== 1'b0 || discard_o !== 1'b0) begin
            errors++;
            $display("FAIL %s: got dec=%b acc=%b dis=%b, expected dec=0 acc=0 dis=0",
                     tag, dec_vld_o, accept_o, discard_o);
        end
    endtask

    // drive one byte at a falling edge; outputs seen here reflect the prior edge
    task automatic put(input logic [7:0] b, input logic s, input logic e);
        @(negedge clk);
        byte_vld_i = 1'b1;
        byte_i     = b;
        sof_i      = s;
        eof_i      = e;
    endtask

    task automatic gap();
        @(negedge clk);
        byte_vld_i = 1'b0;
        sof_i      = 1'b0;
        eof_i      = 1'b0;
        byte_i     = 8'h00;
    endtask

    task automatic setup(input logic [15:0] m, input logic [15:0] a0, input logic [15:0] a1,
                         input logic [15:0] a2, input logic [15:0] a3);
        cfg_mask_i = m;
        cfg_addr_i = {a3, a2, a1, a0};
    endtask

    // full frame: two address bytes then two body bytes that look like addresses
    task automatic frame(input logic [7:0] b0, input logic [7:0] b1, input logic acc,
                         input logic [1:0] idx, input string tag);
        put(b0, 1'b1, 1'b0);
        put(b1, 1'b0, 1'b0);
        chk_quiet({tag, " R7 no early verdict"});
        put(b0, 1'b0, 1'b0);
        chk(1'b1, acc, !acc, idx, tag);
        put(b1, 1'b0, 1'b1);
        chk_quiet({tag, " R9 body byte"});
        gap();
        chk_quiet({tag, " R9 body end"});
    endtask

    task automatic t_reset();
        chk(1'b0, 1'b0, 1'b0, 2'd0, "R1 in reset");
        rst_n = 1'b1;
        gap();
        gap();
        chk(1'b0, 1'b0, 1'b0, 2'd0, "R1 after reset");
    endtask

    task automatic t_full16();
        setup(16'hFFFF, 16'hAA68, 16'hFFFF, 16'h1234, 16'h5678);
        frame(8'h68, 8'hAA, 1'b1, 2'd0, "R2 R3 station 0xAA68");
        frame(8'hAA, 8'h68, 1'b0, 2'd0, "R2 swapped byte order");
        frame(8'hFF, 8'hFF, 1'b1, 2'd1, "R5 broadcast");
        frame(8'h34, 8'h12, 1'b1, 2'd2, "R5 entry 2");
        frame(8'h68, 8'hAB, 1'b0, 2'd2, "R3 one bit off high");
        frame(8'h69, 8'hAA, 1'b0, 2'd2, "R3 one bit off low");
        frame(8'h78, 8'h56, 1'b1, 2'd3, "R5 entry 3");
    endtask

    task automatic t_byte8();
        setup(16'h00FF, 16'h1155, 16'h2266, 16'h3377, 16'h4488);
        frame(8'h55, 8'h00, 1'b1, 2'd0, "R4 low byte only");
        frame(8'h66, 8'hFF, 1'b1, 2'd1, "R4 second byte ignored");
        frame(8'h88, 8'h44, 1'b1, 2'd3, "R4 entry 3");
        frame(8'h99, 8'h11, 1'b0, 2'd3, "R4 mismatch");
    endtask

    task automatic t_priority();
        setup(16'hFFFF, 16'h1111, 16'hBEEF, 16'hBEEF, 16'hBEEF);
        frame(8'hEF, 8'hBE, 1'b1, 2'd1, "R6 duplicate entries");
        setup(16'h00FF, 16'hAA00, 16'h2255, 16'h3355, 16'h4455);
        frame(8'h55, 8'h33, 1'b1, 2'd1, "R6 lowest of three");
        setup(16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
        frame(8'h12, 8'h34, 1'b1, 2'd0, "R6 empty mask all match");
    endtask

    task automatic t_runt();
        setup(16'hFFFF, 16'hAA68, 16'hFFFF, 16'h1234, 16'h5678);
        frame(8'h34, 8'h12, 1'b1, 2'd2, "R8 set index");
        put(8'h68, 1'b1, 1'b1);
        gap();
        chk(1'b1, 1'b0, 1'b1, 2'd2, "R8 runt discard");
        gap();
        chk_quiet("R8 single strobe");
    endtask

    task automatic t_gaps();
        setup(16'hFFFF, 16'hAA68, 16'hFFFF, 16'h1234, 16'h5678);
        put(8'h68, 1'b0, 1'b0);
        put(8'hAA, 1'b0, 1'b1);
        gap();
        chk_quiet("R9 bytes outside frame");
        put(8'h68, 1'b1, 1'b0);
        gap();
        gap();
        byte_i = 8'h00;
        gap();
        chk_quiet("R9 idle cycles");
        put(8'hAA, 1'b0, 1'b0);
        gap();
        chk(1'b1, 1'b1, 1'b0, 2'd0, "R9 gapped address");
        put(8'h00, 1'b0, 1'b1);
        gap();
        chk_quiet("R9 end");
    endtask

    task automatic t_restart();
        setup(16'hFFFF, 16'hAA68, 16'hFFFF, 16'h1234, 16'h5678);
        frame(8'hFF, 8'hFF, 1'b1, 2'd1, "R10 prep");
        put(8'h99, 1'b1, 1'b0);
        put(8'h68, 1'b1, 1'b0);
        chk_quiet("R10 restart no verdict");
        put(8'hAA, 1'b0, 1'b0);
        gap();
        chk(1'b1, 1'b1, 1'b0, 2'd0, "R10 restarted frame");
        put(8'h00, 1'b0, 1'b1);
        gap();
    endtask

    task automatic t_short_two();
        setup(16'hFFFF, 16'h0000, 16'h0000, 16'hAA68, 16'h0000);
        put(8'h68, 1'b1, 1'b0);
        put(8'hAA, 1'b0, 1'b1);
        gap();
        chk(1'b1, 1'b1, 1'b0, 2'd2, "R7 end marker on second byte");
        gap();
        chk_quiet("R7 pulse one cycle");
    endtask

    initial begin
        t_reset();
        t_full16();
        t_byte8();
        t_priority();
        t_runt();
        t_gaps();
        t_restart();
        t_short_two();
        gap();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule